// File: doc/BRIEF.md
# Hashed Filter Table Insert/Delete Engine

This block keeps an open-addressed table of match filters in on-chip storage and carries out insert, replace and delete commands on it. Each command brings a three-bit filter type, three 32-bit match words, a queue number and a precomputed 32-bit key. The engine scrambles the key into a 16-bit hash and derives an odd stride from it. It then walks the double-hashing probe chain one slot per cycle, consulting a per-slot occupancy bit and comparing the stored entry with the request, until it can write, clear or give up.

For every filter type the engine remembers the deepest probe position at which an entry of that type was ever placed. It presents a search limit per type: that depth plus a pipeline allowance of one for exact-match types and three for wildcard types. A lookup pipeline elsewhere on the chip uses these limits to bound its own probing. When the table becomes empty, every recorded depth returns to zero.

Top module: `hft_engine`

## Requirements
- R1: The first slot probed is the low log2(size) bits of the hash. The hash uses a 16-bit variable t. It starts as t = 0x1FFF ^ key[31:16], then applies t ^= (t>>3) ^ (t>>6), then t ^= t>>9, then t ^= (t<<13) ^ key[15:0], and then repeats the two shift steps. Every step is truncated to 16 bits. An insert into an empty table lands on that slot with status OK (status encoding: 0 OK, 1 busy, 2 not found, 3 exists).
- R2: The stride is (2*key - 1) truncated to 16 bits. Each following slot is (slot + stride) modulo the table size. An insert takes the first unoccupied slot on this chain.
- R3: Operation codes: 0 insert, 1 insert-with-replace, 2 or 3 delete. A plain insert that finds an equal occupied entry reports exists and leaves the table unchanged. The replace variant overwrites that slot and reports OK.
- R4: Two entries are equal when their types and all three match words agree. The queue numbers must also agree when type bit 2 is set (transmit direction). For other types the queue number is not compared.
- R5: A search ends after the 200th probed slot. A failing insert then reports busy and a failing delete reports not found.
- R6: A successful insert or replace at probe depth d (1 for the first slot) raises the recorded depth of its type to d if d is larger. Limit output k (bits 8k+7..8k) equals that type's depth + 1 when type bit 0 is 0 (exact match) and depth + 3 when bit 0 is 1 (wildcard).
- R7: A delete that finds an equal entry clears and zeroes its slot, which later inserts can reuse. When the last occupied slot is cleared, all recorded depths return to 0.
- R8: cmd_ready_o is high only while idle and falls in the cycle after a command is accepted. Each command yields exactly one single-cycle done_o pulse carrying the status and the slot index.
- R9: After reset, cmd_ready_o is high, done_o is low and every limit shows its bare allowance (1 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Engine idle, command accepted on valid |
| cmd_op_i | input | 2 | Operation code |
| cmd_type_i | input | 3 | Filter type (bit 0 wildcard, bit 2 transmit) |
| cmd_w0_i | input | 32 | Match word 0 |
| cmd_w1_i | input | 32 | Match word 1 |
| cmd_w2_i | input | 32 | Match word 2 |
| cmd_qid_i | input | 12 | Queue number |
| cmd_key_i | input | 32 | Precomputed hash key |
| done_o | output | 1 | One-cycle completion pulse |
| done_status_o | output | 2 | Completion status |
| done_slot_o | output | log2(TBL_SIZE) | Slot index reached |
| limit_o | output | 8*8 | Per-type search limits, type k in bits 8k+7..8k |

## Verification
The hardest condition to reach from the ports is a probe chain that runs its full 200 hops. The bench reaches it by inserting 200 entries that share one key but differ in a match word. All of them follow the same chain and fill it slot by slot. The 201st insert then reports busy, a delete of an absent entry reports not found, and that type's limit climbs to its ceiling. Draining those entries brings the limits back down. A seeded random phase draws keys from a small pool, which keeps collisions, replaces and transmit queue mismatches frequent.

// File: rtl/hft_pkg.sv
package hft_pkg;
    localparam int WORD_W  = 32;
    localparam int TYPE_W  = 3;
    localparam int QID_W   = 12;
    localparam int N_TYPES = 1 << TYPE_W;
    localparam int WILD_BIT = 0;
    localparam int TX_BIT   = 2;

    typedef enum logic [1:0] {
        OP_INSERT  = 2'd0,
        OP_REPLACE = 2'd1,
        OP_DELETE  = 2'd2,
        OP_DELETE2 = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_BUSY     = 2'd1,
        ST_NOTFOUND = 2'd2,
        ST_EXISTS   = 2'd3
    } status_e;

    typedef struct packed {
        logic [TYPE_W-1:0] typ;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
        logic [QID_W-1:0]  qid;
    } entry_t;

    typedef struct packed {
        op_e    op;
        entry_t ent;
    } cmd_t;

    function automatic logic [15:0] hft_hash16(input logic [31:0] key);
        logic [15:0] t;
        t = 16'h1FFF ^ key[31:16];
        t = t ^ (t >> 3) ^ (t >> 6);
        t = t ^ (t >> 9);
        t = t ^ (t << 13) ^ key[15:0];
        t = t ^ (t >> 3) ^ (t >> 6);
        t = t ^ (t >> 9);
        return t;
    endfunction

    function automatic logic [15:0] hft_stride16(input logic [31:0] key);
        return {key[14:0], 1'b0} - 16'd1;
    endfunction

    function automatic logic hft_same(input entry_t a, input entry_t b);
        logic words_eq;
        words_eq = (a.typ == b.typ) && (a.w0 == b.w0) &&
                   (a.w1 == b.w1) && (a.w2 == b.w2);
        return words_eq && (!a.typ[TX_BIT] || (a.qid == b.qid));
    endfunction
endpackage

// File: rtl/hft_probe_gen.sv
module hft_probe_gen
    import hft_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [31:0]      key_i,
    output logic [IDX_W-1:0] first_idx_o,
    output logic [15:0]      stride_o
);
    logic [15:0] hash;

    always_comb begin
        hash        = hft_hash16(key_i);
        first_idx_o = hash[IDX_W-1:0];
        stride_o    = hft_stride16(key_i);
    end
endmodule

// File: rtl/hft_slot_store.sv
module hft_slot_store
    import hft_pkg::*;
#(
    parameter int TBL_SIZE = 256,
    localparam int IDX_W = $clog2(TBL_SIZE),
    localparam int CNT_W = $clog2(TBL_SIZE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_used_o,
    output entry_t           rd_entry_o,
    input  logic             wr_en_i,
    input  logic             wr_new_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  entry_t           wr_entry_i,
    input  logic             clr_en_i,
    input  logic [IDX_W-1:0] clr_idx_i,
    output logic             drained_o
);
    entry_t              mem_q [TBL_SIZE];
    logic [TBL_SIZE-1:0] used_q;
    logic [CNT_W-1:0]    count_q;

    assign rd_used_o  = used_q[rd_idx_i];
    assign rd_entry_o = mem_q[rd_idx_i];
    assign drained_o  = clr_en_i && (count_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_entry_i;
        end else if (clr_en_i) begin
            mem_q[clr_idx_i] <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q  <= '0;
            count_q <= '0;
        end else if (wr_en_i) begin
            used_q[wr_idx_i] <= 1'b1;
            if (wr_new_i) count_q <= count_q + CNT_W'(1);
        end else if (clr_en_i) begin
            used_q[clr_idx_i] <= 1'b0;
            count_q <= count_q - CNT_W'(1);
        end
    end

    assert_clear_frees_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_en_i && !wr_en_i) |=> !used_q[$past(clr_idx_i)]);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(TBL_SIZE));

    assert_write_marks_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> used_q[$past(wr_idx_i)]);
endmodule

// File: rtl/hft_depth_tracker.sv
module hft_depth_tracker
    import hft_pkg::*;
#(
    parameter int DEPTH_W  = 8,
    parameter int LIM_W    = 8,
    parameter int FULL_PAD = 1,
    parameter int WILD_PAD = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     upd_en_i,
    input  logic [TYPE_W-1:0]        upd_type_i,
    input  logic [DEPTH_W-1:0]       upd_depth_i,
    input  logic                     clr_i,
    output logic [N_TYPES*LIM_W-1:0] limit_o
);
    logic [DEPTH_W-1:0] depth_q [N_TYPES];

    for (genvar t = 0; t < N_TYPES; t++) begin : g_type
        localparam logic [TYPE_W-1:0] TCODE = TYPE_W'(t);
        localparam int PAD = TCODE[WILD_BIT] ? WILD_PAD : FULL_PAD;

        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                depth_q[t] <= '0;
            end else if (upd_en_i && upd_type_i == TCODE &&
                         upd_depth_i > depth_q[t]) begin
                depth_q[t] <= upd_depth_i;
            end
        end

        assign limit_o[t*LIM_W +: LIM_W] = LIM_W'(depth_q[t]) + LIM_W'(PAD);

        assert_depth_monotone_R6: assert property (@(posedge clk) disable iff (rst)
            !clr_i |=> depth_q[t] >= $past(depth_q[t]));

        assert_depth_reset_R7: assert property (@(posedge clk) disable iff (rst)
            clr_i |=> depth_q[t] == '0);
    end
endmodule

// File: rtl/hft_engine.sv
module hft_engine
    import hft_pkg::*;
#(
    parameter int TBL_SIZE = 256,
    parameter int MAX_HOPS = 200,
    parameter int LIM_W    = 8,
    parameter int FULL_PAD = 1,
    parameter int WILD_PAD = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid_i,
    output logic                          cmd_ready_o,
    input  logic [1:0]                    cmd_op_i,
    input  logic [2:0]                    cmd_type_i,
    input  logic [31:0]                   cmd_w0_i,
    input  logic [31:0]                   cmd_w1_i,
    input  logic [31:0]                   cmd_w2_i,
    input  logic [11:0]                   cmd_qid_i,
    input  logic [31:0]                   cmd_key_i,
    output logic                          done_o,
    output logic [1:0]                    done_status_o,
    output logic [$clog2(TBL_SIZE)-1:0]   done_slot_o,
    output logic [8*LIM_W-1:0]            limit_o
);
    localparam int IDX_W   = $clog2(TBL_SIZE);
    localparam int DEPTH_W = $clog2(MAX_HOPS + 1);

    typedef enum logic {S_IDLE, S_PROBE} state_e;

    state_e             state_q;
    cmd_t               cmd_q;
    logic [IDX_W-1:0]   idx_q;
    logic [15:0]        stride_q;
    logic [DEPTH_W-1:0] depth_q;

    logic [IDX_W-1:0]   first_idx;
    logic [15:0]        stride;
    logic               slot_used;
    entry_t             slot_entry;
    logic               drained;

    logic               fin, wr_en, clr_en, upd_en, is_del, hit;
    status_e            fin_status;

    hft_probe_gen #(.IDX_W(IDX_W)) u_probe (
        .key_i       (cmd_key_i),
        .first_idx_o (first_idx),
        .stride_o    (stride)
    );

    hft_slot_store #(.TBL_SIZE(TBL_SIZE)) u_store (
        .clk        (clk),
        .rst        (rst),
        .rd_idx_i   (idx_q),
        .rd_used_o  (slot_used),
        .rd_entry_o (slot_entry),
        .wr_en_i    (wr_en),
        .wr_new_i   (!slot_used),
        .wr_idx_i   (idx_q),
        .wr_entry_i (cmd_q.ent),
        .clr_en_i   (clr_en),
        .clr_idx_i  (idx_q),
        .drained_o  (drained)
    );

    hft_depth_tracker #(
        .DEPTH_W  (DEPTH_W),
        .LIM_W    (LIM_W),
        .FULL_PAD (FULL_PAD),
        .WILD_PAD (WILD_PAD)
    ) u_depth (
        .clk         (clk),
        .rst         (rst),
        .upd_en_i    (upd_en),
        .upd_type_i  (cmd_q.ent.typ),
        .upd_depth_i (depth_q),
        .clr_i       (drained),
        .limit_o     (limit_o)
    );

    assign cmd_ready_o = (state_q == S_IDLE);
    assign is_del      = cmd_q.op[1];
    assign hit         = slot_used && hft_same(slot_entry, cmd_q.ent);

    always_comb begin
        fin        = 1'b0;
        wr_en      = 1'b0;
        clr_en     = 1'b0;
        upd_en     = 1'b0;
        fin_status = ST_OK;
        if (state_q == S_PROBE) begin
            if (hit) begin
                fin = 1'b1;
                if (is_del) begin
                    clr_en = 1'b1;
                end else if (cmd_q.op == OP_REPLACE) begin
                    wr_en  = 1'b1;
                    upd_en = 1'b1;
                end else begin
                    fin_status = ST_EXISTS;
                end
            end else if (!slot_used && !is_del) begin
                fin    = 1'b1;
                wr_en  = 1'b1;
                upd_en = 1'b1;
            end else if (depth_q == DEPTH_W'(MAX_HOPS)) begin
                fin        = 1'b1;
                fin_status = is_del ? ST_NOTFOUND : ST_BUSY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= S_IDLE;
            done_o        <= 1'b0;
            done_status_o <= 2'd0;
            done_slot_o   <= '0;
            cmd_q         <= '0;
            idx_q         <= '0;
            stride_q      <= '0;
            depth_q       <= '0;
        end else begin
            done_o <= fin;
            if (fin) begin
                done_status_o <= fin_status;
                done_slot_o   <= idx_q;
            end
            case (state_q)
                S_IDLE: begin
                    if (cmd_valid_i) begin
                        cmd_q.op      <= op_e'(cmd_op_i);
                        cmd_q.ent.typ <= cmd_type_i;
                        cmd_q.ent.w0  <= cmd_w0_i;
                        cmd_q.ent.w1  <= cmd_w1_i;
                        cmd_q.ent.w2  <= cmd_w2_i;
                        cmd_q.ent.qid <= cmd_qid_i;
                        idx_q         <= first_idx;
                        stride_q      <= stride;
                        depth_q       <= DEPTH_W'(1);
                        state_q       <= S_PROBE;
                    end
                end
                default: begin
                    if (fin) begin
                        state_q <= S_IDLE;
                    end else begin
                        idx_q   <= idx_q + stride_q[IDX_W-1:0];
                        depth_q <= depth_q + DEPTH_W'(1);
                    end
                end
            endcase
        end
    end

    assert_single_done_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

    assert_hop_cap_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PROBE) |-> (depth_q >= DEPTH_W'(1) && depth_q <= DEPTH_W'(MAX_HOPS)));

    assert_busy_at_cap_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && done_status_o == 2'd1) |-> $past(depth_q) == DEPTH_W'(MAX_HOPS));
endmodule

// File: tb/hft_engine_bench.sv
module hft_engine_bench;
    localparam int SIZE = 256;
    localparam int MASK = SIZE - 1;
    localparam int HOPS = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_type = '0;
    logic [31:0] cmd_w0 = '0, cmd_w1 = '0, cmd_w2 = '0;
    logic [11:0] cmd_qid = '0;
    logic [31:0] cmd_key = '0;
    logic        done;
    logic [1:0]  done_status;
    logic [7:0]  done_slot;
    logic [63:0] limits;

    int checks = 0;
    int errors = 0;

    hft_engine u_hft_engine (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid_i   (cmd_valid),
        .cmd_ready_o   (cmd_ready),
        .cmd_op_i      (cmd_op),
        .cmd_type_i    (cmd_type),
        .cmd_w0_i      (cmd_w0),
        .cmd_w1_i      (cmd_w1),
        .cmd_w2_i      (cmd_w2),
        .cmd_qid_i     (cmd_qid),
        .cmd_key_i     (cmd_key),
        .done_o        (done),
        .done_status_o (done_status),
        .done_slot_o   (done_slot),
        .limit_o       (limits)
    );

    always #5 clk = ~clk;

    // reference model state
    bit          m_used [SIZE];
    logic [2:0]  m_typ  [SIZE];
    logic [31:0] m_w0   [SIZE];
    logic [31:0] m_w1   [SIZE];
    logic [31:0] m_w2   [SIZE];
    logic [11:0] m_qid  [SIZE];
    int          m_depth [8];
    int          m_count = 0;

    function automatic logic [15:0] ref_hash(input logic [31:0] k);
        logic [15:0] v;
        v = 16'h1FFF ^ k[31:16];
        v = v ^ (v >> 3) ^ (v >> 6);
        v = v ^ (v >> 9);
        v = v ^ (v << 13) ^ k[15:0];
        v = v ^ (v >> 3) ^ (v >> 6);
        v = v ^ (v >> 9);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_exec(input logic [1:0] op, input logic [2:0] t,
                              input logic [31:0] w0, input logic [31:0] w1,
                              input logic [31:0] w2, input logic [11:0] q,
                              input logic [31:0] key,
                              output int st, output int slot);
        int idx;
        int stp;
        bit eq;
        idx  = int'(ref_hash(key)) & MASK;
        stp  = int'(16'(2 * key - 1));
        st   = 0;
        slot = idx;
        for (int d = 1; d <= HOPS; d++) begin
            eq = m_used[idx] && m_typ[idx] == t && m_w0[idx] == w0 &&
                 m_w1[idx] == w1 && m_w2[idx] == w2 &&
                 (!t[2] || m_qid[idx] == q);
            if (eq) begin
                slot = idx;
                if (op[1]) begin
                    m_used[idx] = 0; m_typ[idx] = 0; m_w0[idx] = 0;
                    m_w1[idx] = 0; m_w2[idx] = 0; m_qid[idx] = 0;
                    m_count--;
                    if (m_count == 0) for (int k = 0; k < 8; k++) m_depth[k] = 0;
                    st = 0;
                end else if (op == 2'd1) begin
                    m_qid[idx] = q;
                    if (d > m_depth[t]) m_depth[t] = d;
                    st = 0;
                end else begin
                    st = 3;
                end
                return;
            end
            if (!m_used[idx] && !op[1]) begin
                slot = idx;
                m_used[idx] = 1; m_typ[idx] = t; m_w0[idx] = w0;
                m_w1[idx] = w1; m_w2[idx] = w2; m_qid[idx] = q;
                m_count++;
                if (d > m_depth[t]) m_depth[t] = d;
                st = 0;
                return;
            end
            if (d == HOPS) begin
                st = op[1] ? 2 : 1;
                return;
            end
            idx = (idx + stp) & MASK;
        end
    endtask

    task automatic chk_limits(input string tag);
        bit ok = 1;
        for (int t = 0; t < 8; t++) begin
            int exp = m_depth[t] + ((t % 2) ? 3 : 1);
            if (int'(limits[t*8 +: 8]) != exp) begin
                ok = 0;
                $display("FAIL %s limit type %0d actual=%0d expected=%0d",
                         tag, t, limits[t*8 +: 8], exp);
            end
        end
        checks++;
        if (!ok) errors++;
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [2:0] t,
                          input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [11:0] q,
                          input logic [31:0] key, input string tag);
        int est, eslot, cyc;
        model_exec(op, t, w0, w1, w2, q, key, est, eslot);
        @(negedge clk);
        cmd_op = op; cmd_type = t; cmd_w0 = w0; cmd_w1 = w1; cmd_w2 = w2;
        cmd_qid = q; cmd_key = key; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R8", "ready while probing", int'(cmd_ready), 0);
        cyc = 0;
        while (done !== 1'b1 && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk(int'(done_status) == est, tag, "status", int'(done_status), est);
        if (est == 0 || est == 3)
            chk(int'(done_slot) == eslot, tag, "slot", int'(done_slot), eslot);
        chk_limits("R6");
        @(negedge clk);
        chk(done == 1'b0, "R8", "done pulse width", int'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] kpool [3];
        for (int i = 0; i < SIZE; i++) m_used[i] = 0;
        for (int k = 0; k < 8; k++) m_depth[k] = 0;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R9", "ready after reset", int'(cmd_ready), 1);
        chk(done == 1'b0, "R9", "done after reset", int'(done), 0);
        chk_limits("R9");

        // R1: first slot; R2: collision follows stride
        do_cmd(2'd0, 3'd0, 32'hA, 32'h11, 32'h22, 12'd1, 32'h1234_5678, "R1");
        do_cmd(2'd0, 3'd0, 32'hB, 32'h11, 32'h22, 12'd1, 32'h1234_5678, "R2");
        // R3: exists vs replace
        do_cmd(2'd0, 3'd0, 32'hA, 32'h11, 32'h22, 12'd1, 32'h1234_5678, "R3");
        do_cmd(2'd1, 3'd0, 32'hA, 32'h11, 32'h22, 12'd7, 32'h1234_5678, "R3");
        // R4: transmit compares queue, receive does not
        do_cmd(2'd0, 3'd4, 32'hC, 32'h1, 32'h2, 12'd5, 32'h0000_0000, "R4");
        do_cmd(2'd2, 3'd4, 32'hC, 32'h1, 32'h2, 12'd6, 32'h0000_0000, "R4");
        do_cmd(2'd0, 3'd4, 32'hC, 32'h1, 32'h2, 12'd5, 32'h0000_0000, "R4");
        do_cmd(2'd0, 3'd1, 32'hD, 32'h3, 32'h4, 12'd1, 32'hDEAD_BEEF, "R4");
        do_cmd(2'd3, 3'd1, 32'hD, 32'h3, 32'h4, 12'd9, 32'hDEAD_BEEF, "R4");
        // R7: delete frees slot, reuse, drain resets depths
        do_cmd(2'd2, 3'd0, 32'hB, 32'h11, 32'h22, 12'd1, 32'h1234_5678, "R7");
        do_cmd(2'd0, 3'd0, 32'hB, 32'h11, 32'h22, 12'd3, 32'h1234_5678, "R7");
        do_cmd(2'd2, 3'd0, 32'hA, 32'h11, 32'h22, 12'd0, 32'h1234_5678, "R7");
        do_cmd(2'd2, 3'd0, 32'hB, 32'h11, 32'h22, 12'd0, 32'h1234_5678, "R7");
        do_cmd(2'd2, 3'd4, 32'hC, 32'h1, 32'h2, 12'd5, 32'h0000_0000, "R7");

        // R5/R6: fill one probe chain to its cap
        for (int i = 0; i < HOPS; i++)
            do_cmd(2'd0, 3'd3, i, 32'h5, 32'h6, 12'd0, 32'hCAFE_0001, "R6");
        do_cmd(2'd0, 3'd3, 32'hFFFF, 32'h5, 32'h6, 12'd0, 32'hCAFE_0001, "R5");
        do_cmd(2'd2, 3'd3, 32'hFFFF, 32'h5, 32'h6, 12'd0, 32'hCAFE_0001, "R5");
        for (int i = 0; i < HOPS; i++)
            do_cmd(2'd2, 3'd3, i, 32'h5, 32'h6, 12'd0, 32'hCAFE_0001, "R7");

        // seeded random mix over a small key pool
        kpool[0] = 32'h0F0F_1111; kpool[1] = 32'h7777_0003; kpool[2] = 32'h0000_8001;
        for (int n = 0; n < 300; n++) begin
            logic [1:0] op;
            op = 2'($urandom % 4);
            if (op == 2'd3 && ($urandom % 2) == 0) op = 2'd0;
            do_cmd(op, 3'($urandom % 8), 32'($urandom % 4), 32'h9, 32'h8,
                   12'($urandom % 2), kpool[$urandom % 3], "R2");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule